// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Carry and Overflow Flags

This block adds or subtracts two operands of a configurable width. One mode bit picks the operation. Subtraction reuses the same adder: every bit of the second operand is inverted, and a carry-in of one is injected. The carry network is split into 4-bit lookahead groups. Each group forms every internal carry in two levels of logic from per-bit generate and propagate terms, and the groups are chained through their group carries.

Two status flags come with each result:
- The carry flag is for unsigned operands. After an addition it reports the end carry. After a subtraction it is high when no borrow was needed.
- The overflow flag is for signed operands. It is the exclusive-OR of the carry into the top bit and the carry out of it.

Result and flags are captured in output registers, so they appear one clock after the operands. A synchronous active-high reset clears them.

Top module: `addsub_flags_unit`

## Requirements
- R1: With `sub_mode` = 0 at a rising edge, `result` after that edge equals (`op_a` + `op_b`) modulo 2^WIDTH.
- R2: With `sub_mode` = 1 at a rising edge, `result` after that edge equals (`op_a` − `op_b`) modulo 2^WIDTH.
- R3: In add mode, `carry_flag` equals bit WIDTH of the unsigned sum `op_a` + `op_b`, which is the end carry.
- R4: In subtract mode, `carry_flag` is 1 when `op_a` ≥ `op_b` as unsigned values (no borrow) and 0 when a borrow occurred. This is checked for every operand pair at WIDTH = 4.
- R5: `ovf_flag` is 1 exactly when the signed result of the selected operation falls outside the range −2^(WIDTH−1) to 2^(WIDTH−1)−1. At WIDTH = 8, both +70 + +80 and −70 + −80 set it.
- R6: The two flags are independent of each other. At WIDTH = 4, −1 + 1 gives `carry_flag` = 1 with `ovf_flag` = 0, and 7 − (−8) gives `carry_flag` = 0 with `ovf_flag` = 1.
- R7: A rising edge with `rst` = 1 clears `result`, `carry_flag` and `ovf_flag` to zero, whatever the operand inputs are.
- R8: WIDTH may be any multiple of 4. Behaviour R1 to R5 holds at WIDTH = 8, where two lookahead groups are chained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| op_a | input | WIDTH | First operand (minuend in subtract mode) |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Registered sum or difference |
| carry_flag | output | 1 | Registered unsigned carry / no-borrow flag |
| ovf_flag | output | 1 | Registered signed overflow flag |

## Verification
A table of hand-worked 4-bit cases targets the four combinations of the two flags. These include a wrap through zero, negative plus negative, a minimum-value subtrahend and equal operands, so each flag is seen to move without the other. An exhaustive sweep of all 4-bit operand pairs in both modes separates the borrow convention from a plain end-carry copy, and it exposes any faulty lookahead term at every bit position. At width 8, a stepping sweep plus the ±70/±80 cases check the hand-off of carries between groups. A reset asserted while operands are live shows that the registers clear regardless of input.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int GROUP_BITS = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic [GROUP_BITS-1:0] gen;
    logic [GROUP_BITS-1:0] prop;
  } gp_terms_t;

endpackage

// File: rtl/addsub_operand_cond.sv
module addsub_operand_cond #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_raw,
  input  logic             mode,
  output logic [WIDTH-1:0] b_eff,
  output logic             carry_seed
);
  // Inverting stage: each bit of B passes through an XOR keyed by the mode.
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_inv
      assign b_eff[i] = b_raw[i] ^ mode;
    end
  endgenerate

  // The +1 of the two's complement enters through the chain carry-in.
  assign carry_seed = mode;
endmodule

// File: rtl/addsub_cla_group.sv
module addsub_cla_group
  import addsub_pkg::*;
(
  input  logic [GROUP_BITS-1:0] a,
  input  logic [GROUP_BITS-1:0] b,
  input  logic                  cin,
  output logic [GROUP_BITS-1:0] sum,
  output logic                  c_top_in,
  output logic                  cout
);
  gp_terms_t t;
  logic c1, c2, c3;

  always_comb begin
    t.gen  = a & b;
    t.prop = a ^ b;
  end

  // Each carry is written out in two-level form from gen, prop and cin,
  // so no carry waits on the one below it.
  always_comb begin
    c1   = t.gen[0]
         | (t.prop[0] & cin);
    c2   = t.gen[1]
         | (t.prop[1] & t.gen[0])
         | (t.prop[1] & t.prop[0] & cin);
    c3   = t.gen[2]
         | (t.prop[2] & t.gen[1])
         | (t.prop[2] & t.prop[1] & t.gen[0])
         | (t.prop[2] & t.prop[1] & t.prop[0] & cin);
    cout = t.gen[3]
         | (t.prop[3] & t.gen[2])
         | (t.prop[3] & t.prop[2] & t.gen[1])
         | (t.prop[3] & t.prop[2] & t.prop[1] & t.gen[0])
         | (t.prop[3] & t.prop[2] & t.prop[1] & t.prop[0] & cin);
  end

  assign sum      = t.prop ^ {c3, c2, c1, cin};
  assign c_top_in = c3;
endmodule

// File: rtl/addsub_cla_chain.sv
module addsub_cla_chain
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_into_msb,
  output logic             c_out
);
  localparam int NGROUPS = WIDTH / GROUP_BITS;

  logic [NGROUPS:0]   grp_carry;
  logic [NGROUPS-1:0] grp_top_in;

  assign grp_carry[0] = cin;

  genvar k;
  generate
    for (k = 0; k < NGROUPS; k++) begin : g_grp
      addsub_cla_group u_grp (
        .a        (a[k*GROUP_BITS +: GROUP_BITS]),
        .b        (b[k*GROUP_BITS +: GROUP_BITS]),
        .cin      (grp_carry[k]),
        .sum      (sum[k*GROUP_BITS +: GROUP_BITS]),
        .c_top_in (grp_top_in[k]),
        .cout     (grp_carry[k+1])
      );
    end
  endgenerate

  assign c_into_msb = grp_top_in[NGROUPS-1];
  assign c_out      = grp_carry[NGROUPS];
endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_flag,
  output logic             ovf_flag
);
  op_mode_e         mode;
  logic [WIDTH-1:0] b_eff;
  logic             seed;
  logic [WIDTH-1:0] sum_c;
  logic             c_msb_in;
  logic             c_end;

  assign mode = op_mode_e'(sub_mode);

  addsub_operand_cond #(.WIDTH(WIDTH)) u_cond (
    .b_raw      (op_b),
    .mode       (mode == OP_SUB),
    .b_eff      (b_eff),
    .carry_seed (seed)
  );

  addsub_cla_chain #(.WIDTH(WIDTH)) u_chain (
    .a          (op_a),
    .b          (b_eff),
    .cin        (seed),
    .sum        (sum_c),
    .c_into_msb (c_msb_in),
    .c_out      (c_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      carry_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      result     <= sum_c;
      carry_flag <= c_end;
      ovf_flag   <= c_msb_in ^ c_end;
    end
  end
endmodule

// File: rtl/addsub_flags_checker.sv
module addsub_flags_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_mode,
  input logic [WIDTH-1:0] result,
  input logic             carry_flag,
  input logic             ovf_flag
);
  localparam int MSB = WIDTH - 1;

  logic             armed = 1'b0;
  logic             mode_q;
  logic [WIDTH:0]   add_ext_q;
  logic [WIDTH-1:0] diff_q;
  logic             ge_q;
  logic             v_add_q;
  logic             v_sub_q;
  logic [WIDTH:0]   add_ext;
  logic [WIDTH-1:0] diff;

  assign add_ext = {1'b0, op_a} + {1'b0, op_b};
  assign diff    = op_a - op_b;

  // Behavioural reference registered alongside the design's outputs.
  always_ff @(posedge clk) begin
    armed     <= !rst;
    mode_q    <= sub_mode;
    add_ext_q <= add_ext;
    diff_q    <= diff;
    ge_q      <= (op_a >= op_b);
    v_add_q   <= (op_a[MSB] == op_b[MSB]) && (add_ext[MSB] != op_a[MSB]);
    v_sub_q   <= (op_a[MSB] != op_b[MSB]) && (diff[MSB] != op_a[MSB]);
  end

  a_r1_add_sum: assert property (@(posedge clk) disable iff (rst)
    (armed && !mode_q) |-> (result == add_ext_q[WIDTH-1:0]));

  a_r2_sub_diff: assert property (@(posedge clk) disable iff (rst)
    (armed && mode_q) |-> (result == diff_q));

  a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
    (armed && !mode_q) |-> (carry_flag == add_ext_q[WIDTH]));

  a_r4_no_borrow: assert property (@(posedge clk) disable iff (rst)
    (armed && mode_q) |-> (carry_flag == ge_q));

  a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
    armed |-> (ovf_flag == (mode_q ? v_sub_q : v_add_q)));
endmodule

bind addsub_flags_unit addsub_flags_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_a       (op_a),
  .op_b       (op_b),
  .sub_mode   (sub_mode),
  .result     (result),
  .carry_flag (carry_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/addsub_flags_unit_test.sv
`timescale 1ns/1ps
module addsub_flags_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0] a4 = '0, b4 = '0;
  logic       m4 = 1'b0;
  logic [3:0] r4;
  logic       c4, v4;
  logic [7:0] a8 = '0, b8 = '0;
  logic       m8 = 1'b0;
  logic [7:0] r8;
  logic       c8, v8;

  addsub_flags_unit #(.WIDTH(4)) uut (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .sub_mode(m4),
    .result(r4), .carry_flag(c4), .ovf_flag(v4));

  addsub_flags_unit #(.WIDTH(8)) uut_w8 (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sub_mode(m8),
    .result(r8), .carry_flag(c8), .ovf_flag(v8));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Fields: a[14:11] b[10:7] mode[6] result[5:2] carry[1] ovf[0]
  localparam logic [14:0] VEC [12] = '{
    {4'd3,  4'd4, 1'b0, 4'd7,  1'b0, 1'b0},
    {4'd7,  4'd1, 1'b0, 4'd8,  1'b0, 1'b1},
    {4'd15, 4'd1, 1'b0, 4'd0,  1'b1, 1'b0},  // R6: C=1, V=0
    {4'd8,  4'd8, 1'b0, 4'd0,  1'b1, 1'b1},
    {4'd6,  4'd6, 1'b0, 4'd12, 1'b0, 1'b1},
    {4'd5,  4'd3, 1'b1, 4'd2,  1'b1, 1'b0},
    {4'd3,  4'd5, 1'b1, 4'd14, 1'b0, 1'b0},
    {4'd0,  4'd1, 1'b1, 4'd15, 1'b0, 1'b0},
    {4'd8,  4'd1, 1'b1, 4'd7,  1'b1, 1'b1},
    {4'd7,  4'd8, 1'b1, 4'd15, 1'b0, 1'b1},  // R6: C=0, V=1
    {4'd9,  4'd9, 1'b1, 4'd0,  1'b1, 1'b0},
    {4'd0,  4'd0, 1'b1, 4'd0,  1'b1, 1'b0}
  };

  function automatic void model(input int w, input int a, input int b, input bit m,
                                output int r, output bit c, output bit v);
    int md, half, sa, sb, sr;
    md   = 1 << w;
    half = 1 << (w - 1);
    r    = m ? ((a - b + md) % md) : ((a + b) % md);
    c    = m ? (a >= b) : ((a + b) >= md);
    sa   = (a >= half) ? a - md : a;
    sb   = (b >= half) ? b - md : b;
    sr   = m ? sa - sb : sa + sb;
    v    = (sr >= half) || (sr < -half);
  endfunction

  task automatic check(input string req, input int got, input int exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  task automatic run4(input int a, input int b, input bit m, output int r, output bit c, output bit v);
    @(negedge clk);
    a4 = 4'(a); b4 = 4'(b); m4 = m;
    @(negedge clk);
    r = int'(r4); c = c4; v = v4;
  endtask

  task automatic run8(input int a, input int b, input bit m, output int r, output bit c, output bit v);
    @(negedge clk);
    a8 = 8'(a); b8 = 8'(b); m8 = m;
    @(negedge clk);
    r = int'(r8); c = c8; v = v8;
  endtask

  task automatic full_check(input int w, input int a, input int b, input bit m,
                            input int r, input bit c, input bit v);
    int er; bit ec, ev;
    model(w, a, b, m, er, ec, ev);
    if (m) begin
      check("R2", r, er, "difference");
      check("R4", int'(c), int'(ec), "no-borrow flag");
    end else begin
      check("R1", r, er, "sum");
      check("R3", int'(c), int'(ec), "end carry");
    end
    check("R5", int'(v), int'(ev), "overflow");
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r; bit c, v;
    // R7: outputs cleared while reset is held
    a4 = 4'd9; b4 = 4'd9; a8 = 8'd200; b8 = 8'd100;
    repeat (3) @(negedge clk);
    check("R7", int'(r4), 0, "reset result w4");
    check("R7", int'({c4, v4}), 0, "reset flags w4");
    check("R7", int'(r8), 0, "reset result w8");
    check("R7", int'({c8, v8}), 0, "reset flags w8");
    rst = 1'b0;

    // Table of hand-worked vectors (R1..R6)
    for (int i = 0; i < 12; i++) begin
      run4(int'(VEC[i][14:11]), int'(VEC[i][10:7]), VEC[i][6], r, c, v);
      check(VEC[i][6] ? "R2" : "R1", r, int'(VEC[i][5:2]), "table result");
      check(VEC[i][6] ? "R4" : "R3", int'(c), int'(VEC[i][1]), "table carry");
      check("R5", int'(v), int'(VEC[i][0]), "table overflow");
      if (i == 2 || i == 9)
        check("R6", int'({c, v}), int'(VEC[i][1:0]), "flag independence");
    end

    // Exhaustive width-4 sweep, both modes (R4 convention covered fully)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          run4(a, b, bit'(m), r, c, v);
          full_check(4, a, b, bit'(m), r, c, v);
        end

    // R8: width-8 stepping sweep across group boundary
    for (int i = 0; i < 200; i++) begin
      int a, b;
      a = (i * 37 + 11) % 256;
      b = (i * 91 + 5) % 256;
      run8(a, b, bit'(i % 2), r, c, v);
      full_check(8, a, b, bit'(i % 2), r, c, v);
    end

    // R5 at width 8: +70 + +80 and -70 + -80
    run8(70, 80, 1'b0, r, c, v);
    check("R5", int'(v), 1, "+70+80 overflow");
    check("R8", r, 150, "+70+80 result");
    run8(186, 176, 1'b0, r, c, v);
    check("R5", int'(v), 1, "-70-80 overflow");
    check("R8", r, 106, "-70-80 result");
    check("R3", int'(c), 1, "-70-80 end carry");
    run8(128, 128, 1'b1, r, c, v);
    check("R4", int'(c), 1, "equal operands no borrow");
    check("R5", int'(v), 0, "-128 minus -128");

    // R7: reset asserted with live operands
    run4(7, 7, 1'b0, r, c, v);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R7", int'(r4), 0, "mid-run reset result");
    check("R7", int'({c4, v4}), 0, "mid-run reset flags");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(r4), 14, "recovery after reset");
    check("R5", int'(v4), 1, "recovery overflow");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule